// File: doc/BRIEF.md
# Dictionary-Compressed Data Bus Codec

This block sends 32-bit words from an encoder to a decoder over a link and avoids toggling the high-order lines when a word repeats recently seen upper bits. Each word is split into three fields. Bits [15:12] are the index and bits [11:0] are the low field. These two always travel on the 16 narrow lines. Bits [31:16] are the upper field. The index picks one of 16 entries in a dictionary that holds previously sent upper fields.

On every transfer the encoder compares the upper field with the selected entry. When the entry is valid and equal, the beat is sent packed: the hit flag is set, the upper-line output enable is low, and the upper lines keep their last value, as a floating bus with a keeper would. Otherwise the beat is sent full: the upper field is driven and both sides write it into the selected entry. The decoder keeps an identical dictionary. On a hit it rebuilds the upper field from that dictionary and never looks at the upper lines.

The encoder beat is a small state machine that is re-evaluated on every clock edge. `BEAT_IDLE` means no transfer. `BEAT_FULL` means a miss with the upper lines driven. `BEAT_PACKED` means a hit with the upper lines released. From any state, the next state is `BEAT_IDLE` when `in_valid` is low, `BEAT_PACKED` when `in_valid` is high and the lookup hits, and `BEAT_FULL` otherwise. Two counters record transfers and hits so that the match rate can be measured.

Top module: `dict_bus_codec`

## Requirements
- R1: `link_rest` carries `in_word[15:0]` (index in bits [15:12], low field in [11:0]) on the link beat that follows an accepted word, and the dictionary entry used is the one named by `in_word[15:12]`.
- R2: An accepted word whose index entry is invalid or holds a different upper field produces, one clock later, `link_valid`=1, `link_hit`=0, `link_upper_oe`=1 and `link_upper` = `in_word[31:16]`.
- R3: An accepted word whose index entry is valid and equal to `in_word[31:16]` produces, one clock later, `link_valid`=1, `link_hit`=1 and `link_upper_oe`=0.
- R4: A miss writes the upper field into the indexed entry of both dictionaries, so the next word with the same index and upper field hits, and a changed upper field on that index misses and replaces the entry.
- R5: While `link_upper_oe` is 0, `link_upper` holds the value it had in the previous cycle; it is 0 after reset.
- R6: One clock after each link beat, `out_valid`=1 and `out_word` equals the original word; on a hit the upper field comes from the decoder dictionary, not from the upper lines.
- R7: Reset invalidates every entry, so the first word on each index after reset misses, even when its upper field is zero.
- R8: `xfer_count` counts accepted words and `hit_count` counts hits, both updated in the same cycle as the corresponding link beat and cleared by reset.
- R9: A cycle with `in_valid`=0 yields `link_valid`=0, `link_hit`=0, `link_upper_oe`=0, and leaves the dictionaries and counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word presented to encoder |
| in_word | input | 32 | Word to send |
| link_valid | output | 1 | Link beat present |
| link_hit | output | 1 | Beat is packed (upper lines released) |
| link_upper_oe | output | 1 | Enable for the upper lines |
| link_upper | output | 16 | Upper lines |
| link_rest | output | 16 | Index and low-field lines |
| out_valid | output | 1 | Decoded word valid |
| out_word | output | 32 | Decoded word |
| hit_count | output | 32 | Number of packed beats |
| xfer_count | output | 32 | Number of accepted words |

## Verification
The bench targets a first use of an index after reset with a zero upper field. A design that hit on cleared storage would report a packed beat there and the decoder would rebuild a wrong word. It alternates two upper values on one index and sends back-to-back repeats, which expose a refresh that is missing, late or sent to the wrong entry: the hit pattern then drifts from the model, or the decoder dictionary falls out of step and corrupts output words. Random traffic over a small pool of upper values mixes hits, misses and idle cycles. This catches upper lines that move while released, counters that are off by one beat, and a decoder that takes its upper field from the stale lines.

// File: rtl/codec_pkg.sv
package codec_pkg;
    localparam int WORD_W  = 32;
    localparam int UPPER_W = 16;
    localparam int IDX_W   = 4;
    localparam int LOW_W   = WORD_W - UPPER_W - IDX_W;
    localparam int CNT_W   = 32;

    typedef enum logic [1:0] {
        BEAT_IDLE   = 2'd0,
        BEAT_FULL   = 2'd1,
        BEAT_PACKED = 2'd2
    } beat_e;
endpackage

// File: rtl/dict_store.sv
module dict_store #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [DATA_W-1:0]  mem [ENTRIES];
    logic [ENTRIES-1:0] vld;

    // valid bits carry the reset; payload does not need one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data  = mem[rd_idx];
    assign rd_valid = vld[rd_idx];

    // R7: an entry read straight after reset is never valid
    a_r7_clear_on_reset: assert property (@(posedge clk)
        !rst_n |=> (vld == '0));
endmodule

// File: rtl/dict_encoder.sv
module dict_encoder
    import codec_pkg::*;
#(
    parameter int UW = UPPER_W,
    parameter int IW = IDX_W,
    parameter int LW = LOW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [UW+IW+LW-1:0] in_word,
    output logic             link_valid,
    output logic             link_hit,
    output logic             link_upper_oe,
    output logic [UW-1:0]    link_upper,
    output logic [IW+LW-1:0] link_rest,
    output logic             ev_xfer,
    output logic             ev_hit
);
    localparam int RW = IW + LW;

    logic [UW-1:0] w_upper;
    logic [IW-1:0] w_idx;
    logic [UW-1:0] d_data;
    logic          d_valid;
    logic          lookup_hit;

    beat_e         beat_q, beat_d;
    logic [UW-1:0] upper_q;
    logic [RW-1:0] rest_q;

    assign w_upper = in_word[RW +: UW];
    assign w_idx   = in_word[LW +: IW];

    dict_store #(.IDX_W(IW), .DATA_W(UW)) u_dict (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (w_idx),
        .rd_data  (d_data),
        .rd_valid (d_valid),
        .wr_en    (in_valid && !lookup_hit),
        .wr_idx   (w_idx),
        .wr_data  (w_upper)
    );

    assign lookup_hit = in_valid && d_valid && (d_data == w_upper);
    assign ev_xfer    = in_valid;
    assign ev_hit     = lookup_hit;

    // next beat
    always_comb begin
        if (!in_valid) begin
            beat_d = BEAT_IDLE;
        end else if (lookup_hit) begin
            beat_d = BEAT_PACKED;
        end else begin
            beat_d = BEAT_FULL;
        end
    end

    // state register and line registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q  <= BEAT_IDLE;
            upper_q <= '0;
            rest_q  <= '0;
        end else begin
            beat_q <= beat_d;
            if (in_valid) begin
                rest_q <= in_word[RW-1:0];
            end
            if (in_valid && !lookup_hit) begin
                upper_q <= w_upper;
            end
        end
    end

    // outputs from state
    always_comb begin
        link_valid    = 1'b0;
        link_hit      = 1'b0;
        link_upper_oe = 1'b0;
        unique case (beat_q)
            BEAT_IDLE: begin
                link_valid = 1'b0;
            end
            BEAT_FULL: begin
                link_valid    = 1'b1;
                link_upper_oe = 1'b1;
            end
            BEAT_PACKED: begin
                link_valid = 1'b1;
                link_hit   = 1'b1;
            end
            default: begin
                link_valid = 1'b0;
            end
        endcase
    end

    assign link_upper = upper_q;
    assign link_rest  = rest_q;

    a_r3_packed_released: assert property (@(posedge clk) disable iff (!rst_n)
        link_hit |-> (link_valid && !link_upper_oe));

    a_r5_lines_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !link_upper_oe |-> $stable(link_upper));

    a_r9_idle_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!link_valid && !link_upper_oe));

    a_r2_miss_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lookup_hit) |=> (link_upper_oe && link_upper == $past(w_upper)));
endmodule

// File: rtl/dict_decoder.sv
module dict_decoder
    import codec_pkg::*;
#(
    parameter int UW = UPPER_W,
    parameter int IW = IDX_W,
    parameter int LW = LOW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_valid,
    input  logic             link_hit,
    input  logic [UW-1:0]    link_upper,
    input  logic [IW+LW-1:0] link_rest,
    output logic             out_valid,
    output logic [UW+IW+LW-1:0] out_word
);
    localparam int RW = IW + LW;

    logic [IW-1:0] l_idx;
    logic [UW-1:0] d_data;
    logic          d_valid;
    logic [UW-1:0] upper_sel;

    assign l_idx = link_rest[LW +: IW];

    dict_store #(.IDX_W(IW), .DATA_W(UW)) u_dict (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (l_idx),
        .rd_data  (d_data),
        .rd_valid (d_valid),
        .wr_en    (link_valid && !link_hit),
        .wr_idx   (l_idx),
        .wr_data  (link_upper)
    );

    // upper lines are not looked at on a packed beat
    assign upper_sel = link_hit ? d_data : link_upper;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= link_valid;
            if (link_valid) begin
                out_word <= {upper_sel, link_rest};
            end
        end
    end

    // R4: decoder dictionary must be in step with encoder on a packed beat
    a_r4_dict_in_step: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && link_hit) |-> d_valid);

    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid |=> out_valid);
endmodule

// File: rtl/codec_stats.sv
module codec_stats #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_xfer,
    input  logic          ev_hit,
    output logic [CW-1:0] hit_count,
    output logic [CW-1:0] xfer_count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count  <= '0;
            xfer_count <= '0;
        end else begin
            if (ev_xfer) xfer_count <= xfer_count + 1'b1;
            if (ev_hit)  hit_count  <= hit_count + 1'b1;
        end
    end

    a_r8_hits_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count <= xfer_count);
endmodule

// File: rtl/dict_bus_codec.sv
module dict_bus_codec
    import codec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [WORD_W-1:0]    in_word,
    output logic                 link_valid,
    output logic                 link_hit,
    output logic                 link_upper_oe,
    output logic [UPPER_W-1:0]   link_upper,
    output logic [IDX_W+LOW_W-1:0] link_rest,
    output logic                 out_valid,
    output logic [WORD_W-1:0]    out_word,
    output logic [CNT_W-1:0]     hit_count,
    output logic [CNT_W-1:0]     xfer_count
);
    logic ev_xfer;
    logic ev_hit;

    dict_encoder #(.UW(UPPER_W), .IW(IDX_W), .LW(LOW_W)) u_enc (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_word       (in_word),
        .link_valid    (link_valid),
        .link_hit      (link_hit),
        .link_upper_oe (link_upper_oe),
        .link_upper    (link_upper),
        .link_rest     (link_rest),
        .ev_xfer       (ev_xfer),
        .ev_hit        (ev_hit)
    );

    dict_decoder #(.UW(UPPER_W), .IW(IDX_W), .LW(LOW_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_valid (link_valid),
        .link_hit   (link_hit),
        .link_upper (link_upper),
        .link_rest  (link_rest),
        .out_valid  (out_valid),
        .out_word   (out_word)
    );

    codec_stats #(.CW(CNT_W)) u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_xfer    (ev_xfer),
        .ev_hit     (ev_hit),
        .hit_count  (hit_count),
        .xfer_count (xfer_count)
    );
endmodule

// File: tb/tb_dict_bus_codec.sv
`timescale 1ns/1ps
module tb_dict_bus_codec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        link_valid, link_hit, link_upper_oe;
    logic [15:0] link_upper, link_rest;
    logic        out_valid;
    logic [31:0] out_word;
    logic [31:0] hit_count, xfer_count;

    always #4 clk = ~clk;

    dict_bus_codec dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .link_valid(link_valid), .link_hit(link_hit), .link_upper_oe(link_upper_oe),
        .link_upper(link_upper), .link_rest(link_rest),
        .out_valid(out_valid), .out_word(out_word),
        .hit_count(hit_count), .xfer_count(xfer_count)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // model
    logic [15:0] m_dict [16];
    logic [15:0] m_vld;
    logic [15:0] m_line;
    logic [31:0] m_hits, m_xfers;
    logic        e_lv, e_hit, e_oe;
    logic [31:0] e_word;
    logic        d_ov;
    logic [31:0] d_ow;
    string       hit_tag;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic model_hit(input logic [3:0] idx, input logic [15:0] up);
        return m_vld[idx] && (m_dict[idx] == up);
    endfunction

    task automatic model_clear();
        m_vld = '0; m_line = '0; m_hits = '0; m_xfers = '0;
        e_lv = 0; e_hit = 0; e_oe = 0; e_word = '0; d_ov = 0; d_ow = '0;
        hit_tag = "R3";
    endtask

    task automatic check_all();
        chk(e_lv ? "R2" : "R9", "link_valid", {31'd0, link_valid}, {31'd0, e_lv});
        chk(hit_tag, "link_hit", {31'd0, link_hit}, {31'd0, e_hit});
        chk(e_lv ? "R2" : "R9", "link_upper_oe", {31'd0, link_upper_oe}, {31'd0, e_oe});
        chk("R5", "link_upper", {16'd0, link_upper}, {16'd0, m_line});
        if (e_lv) chk("R1", "link_rest", {16'd0, link_rest}, {16'd0, e_word[15:0]});
        chk("R6", "out_valid", {31'd0, out_valid}, {31'd0, d_ov});
        if (d_ov) chk("R6", "out_word", out_word, d_ow);
        chk("R8", "xfer_count", xfer_count, m_xfers);
        chk("R8", "hit_count", hit_count, m_hits);
    endtask

    task automatic step(input logic v, input logic [31:0] w, input string tag);
        logic h;
        @(negedge clk);
        check_all();
        d_ov = e_lv; d_ow = e_word;
        h = 1'b0;
        if (v) begin
            h = model_hit(w[15:12], w[31:16]);
            if (!h) begin
                m_vld[w[15:12]] = 1'b1;
                m_dict[w[15:12]] = w[31:16];
                m_line = w[31:16];
            end
            m_xfers++;
            if (h) m_hits++;
        end
        e_lv = v; e_word = w; e_hit = h; e_oe = v && !h;
        hit_tag = tag;
        in_valid = v; in_word = w;
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 0; rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R7", "reset link_valid", {31'd0, link_valid}, 32'd0);
        chk("R7", "reset oe", {31'd0, link_upper_oe}, 32'd0);
        chk("R7", "reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R8", "reset xfer_count", xfer_count, 32'd0);
        chk("R8", "reset hit_count", hit_count, 32'd0);
        chk("R5", "reset upper lines", {16'd0, link_upper}, 32'd0);
        model_clear();
        rst_n = 1;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        model_clear();
        do_reset();

        // R7: first use after reset with zero upper must miss
        step(1, 32'h0000_3abc, "R7");
        step(1, 32'h0000_3abc, "R4");           // repeat hits
        step(1, 32'h0000_3abc, "R4");
        step(1, 32'h1234_3001, "R4");           // changed upper misses
        step(1, 32'h0000_3002, "R4");           // old value evicted
        step(1, 32'h0000_3003, "R4");
        step(0, 32'hdead_beef, "R9");           // idle
        step(1, 32'h0000_4abc, "R7");           // other index: first use
        step(1, 32'hffff_f123, "R3");
        step(1, 32'hffff_f456, "R3");
        step(0, 32'h0, "R9");
        step(0, 32'h0, "R9");

        // random traffic over a small upper pool
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] pool [4];
            logic [31:0] w;
            pool[0] = 16'h0000; pool[1] = 16'h8001; pool[2] = 16'h7ffe; pool[3] = 16'hc35a;
            w[31:16] = pool[$urandom_range(0, 3)];
            w[15:12] = 4'($urandom_range(0, 15));
            w[11:0]  = 12'($urandom);
            step($urandom_range(0, 9) < 8, w, "R3");
        end

        // second reset: stored entries must be forgotten
        step(1, 32'h5555_7aaa, "R4");
        step(1, 32'h5555_7aaa, "R4");
        do_reset();
        step(1, 32'h5555_7aaa, "R7");
        step(1, 32'h5555_7aaa, "R4");
        step(0, 32'h0, "R9");
        step(0, 32'h0, "R9");
        step(0, 32'h0, "R9");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule